// File: doc/BRIEF.md
# DDR Burst-of-Four SRAM Core

This block is a single-clock, synthesizable model of a pipelined double-data-rate static RAM in which every access moves a fixed burst of four words. A command port samples an active-low load strobe, a read/write select and a word address on the rising clock edge. The double-rate data bus is modelled as two beats per clock cycle: one bus carries the beat tied to the rising edge and a second bus carries the beat tied to the complementary edge. One burst therefore takes two clock cycles on the data buses.

The low two address bits choose the first word of the burst. The burst then steps linearly and wraps inside the aligned group of four words. While a burst is running, the command port is deaf. Read beats come with a valid flag. A reference-select output tells the receiver whether the beats are referenced to the output clock pair or to the input clock pair. That choice is made by a static configuration pin, captured when the read is loaded. The data path has no back-pressure: a read burst cannot be stalled, and a write burst must supply its beats in the two cycles that follow the load.

Top module: `ddr_b4_sram`

## Requirements
- R1: A command is taken on a rising edge when `cmd_ld_n` is 0 and no burst is running. `cmd_rd_nwr` = 1 makes it a read and 0 makes it a write. A write never raises `rd_valid`.
- R2: After an accepted read, `rd_valid` is 1 for exactly the two cycles that follow the load cycle. Words 1 and 2 of the burst appear on `rd_rise`/`rd_fall` in the first of these cycles, and words 3 and 4 appear in the second.
- R3: Word k (k = 0..3) of a burst addresses `{addr[ADDR_W-1:2], (addr[1:0]+k) mod 4}`. For example, start offset 2 gives the order 2,3,0,1 and start offset 3 gives 3,0,1,2.
- R4: For a write, `wr_rise`/`wr_fall` in the cycle after the load carry words 1 and 2, and in the next cycle they carry words 3 and 4. All four words are in the array when the burst ends.
- R5: A load during either cycle of a running burst is ignored. It starts no burst, writes nothing, and its address is unused.
- R6: `rd_ref_in_clk` takes the value of `use_in_clk_ref` at the accepted load and holds it through the read beats. 1 means the input clock pair is the reference and 0 means the output clock pair is.
- R7: Out of reset, `rd_valid` is 0. Whenever `rd_valid` is 0, `rd_rise` and `rd_fall` are 0.
- R8: A load in the cycle right after a burst's second cycle is accepted, so bursts can run back to back. A read issued straight after a write burst returns the newly written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ld_n | input | 1 | Active-low load strobe that starts a burst |
| cmd_rd_nwr | input | 1 | Direction: 1 read, 0 write |
| cmd_addr | input | ADDR_W | Word address; bits [1:0] give the start offset |
| use_in_clk_ref | input | 1 | Static configuration: reference read beats to the input clock pair |
| wr_rise | input | DATA_W | Write beat for the rising-edge half of the cycle |
| wr_fall | input | DATA_W | Write beat for the falling-edge half of the cycle |
| rd_rise | output | DATA_W | Read beat for words 1 and 3 |
| rd_fall | output | DATA_W | Read beat for words 2 and 4 |
| rd_valid | output | 1 | Read beats present |
| rd_ref_in_clk | output | 1 | Reference for the read beats: 1 input clock pair, 0 output clock pair |

## Verification
The hardest case to reach from the ports is a load that arrives in the middle of a burst, because its effect must be nothing at all. The stimulus issues a conflicting command in both burst cycles. A read is pressed into a write burst, and any spurious beats it produced would be caught by the monitor. A write with garbage data is pressed into a read burst, and a later read of its target address must show the old contents. Bursts also run back to back, with start offsets 0, 2 and 3 and both reference settings.

// File: rtl/ddr_b4_pkg.sv
package ddr_b4_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_t;

  localparam int BEATS_PER_CYCLE = 2;

  // word slot inside the aligned group of four, wrapping
  function automatic logic [1:0] slot_of(input logic [1:0] start, input logic [1:0] k);
    return start + k;
  endfunction
endpackage

// File: rtl/ddr_b4_cmd_ctrl.sv
module ddr_b4_cmd_ctrl
  import ddr_b4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ref_in,
  output phase_t            phase,
  output logic [ADDR_W-1:0] base_addr,
  output logic              is_read,
  output logic              ref_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      base_addr <= '0;
      is_read   <= 1'b0;
      ref_sel   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (!ld_n) begin
            phase     <= PH_FIRST;
            base_addr <= addr;
            is_read   <= rd_nwr;
            ref_sel   <= ref_in;
          end
        end
        PH_FIRST:  phase <= PH_SECOND;
        PH_SECOND: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_b4_burst_seq.sv
module ddr_b4_burst_seq
  import ddr_b4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr_rise,
  output logic [ADDR_W-1:0] addr_fall
);
  localparam int GRP_W = ADDR_W - 2;

  logic [1:0] k_rise;
  logic [1:0] k_fall;

  always_comb begin
    k_rise = (phase == PH_SECOND) ? 2'd2 : 2'd0;
    k_fall = k_rise + 2'd1;
    addr_rise = {base_addr[ADDR_W-1 -: GRP_W], slot_of(base_addr[1:0], k_rise)};
    addr_fall = {base_addr[ADDR_W-1 -: GRP_W], slot_of(base_addr[1:0], k_fall)};
  end
endmodule

// File: rtl/ddr_b4_array.sv
module ddr_b4_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] a_rise,
  input  logic [ADDR_W-1:0] a_fall,
  input  logic [DATA_W-1:0] wd_rise,
  input  logic [DATA_W-1:0] wd_fall,
  output logic [DATA_W-1:0] rd_rise,
  output logic [DATA_W-1:0] rd_fall
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // the two beat addresses of one cycle always differ in slot
  always_ff @(posedge clk) begin
    if (we) begin
      mem[a_rise] <= wd_rise;
      mem[a_fall] <= wd_fall;
    end
  end

  assign rd_rise = mem[a_rise];
  assign rd_fall = mem[a_fall];
endmodule

// File: rtl/ddr_b4_sram.sv
module ddr_b4_sram
  import ddr_b4_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ld_n,
  input  logic              cmd_rd_nwr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              use_in_clk_ref,
  input  logic [DATA_W-1:0] wr_rise,
  input  logic [DATA_W-1:0] wr_fall,
  output logic [DATA_W-1:0] rd_rise,
  output logic [DATA_W-1:0] rd_fall,
  output logic              rd_valid,
  output logic              rd_ref_in_clk
);
  phase_t            phase;
  logic [ADDR_W-1:0] base_addr;
  logic              is_read;
  logic              ref_sel;
  logic [ADDR_W-1:0] a_rise;
  logic [ADDR_W-1:0] a_fall;
  logic [DATA_W-1:0] m_rise;
  logic [DATA_W-1:0] m_fall;
  logic              active;
  logic              burst_idle;
  logic              wr_en;

  ddr_b4_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_n     (cmd_ld_n),
    .rd_nwr   (cmd_rd_nwr),
    .addr     (cmd_addr),
    .ref_in   (use_in_clk_ref),
    .phase    (phase),
    .base_addr(base_addr),
    .is_read  (is_read),
    .ref_sel  (ref_sel)
  );

  ddr_b4_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .phase    (phase),
    .base_addr(base_addr),
    .addr_rise(a_rise),
    .addr_fall(a_fall)
  );

  ddr_b4_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .we     (wr_en),
    .a_rise (a_rise),
    .a_fall (a_fall),
    .wd_rise(wr_rise),
    .wd_fall(wr_fall),
    .rd_rise(m_rise),
    .rd_fall(m_fall)
  );

  assign burst_idle    = (phase == PH_IDLE);
  assign active        = !burst_idle;
  assign wr_en         = active && !is_read;
  assign rd_valid      = active && is_read;
  assign rd_rise       = rd_valid ? m_rise : '0;
  assign rd_fall       = rd_valid ? m_fall : '0;
  assign rd_ref_in_clk = ref_sel;
endmodule

// File: rtl/ddr_b4_sram_chk.sv
module ddr_b4_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ld_n,
  input logic              cmd_rd_nwr,
  input logic              use_in_clk_ref,
  input logic              burst_idle,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_rise,
  input logic [DATA_W-1:0] rd_fall,
  input logic              rd_ref_in_clk
);
  // R1
  rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ld_n && cmd_rd_nwr && burst_idle) |=> rd_valid);

  // R1
  wr_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ld_n && !cmd_rd_nwr && burst_idle) |=> !rd_valid);

  // R2
  valid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |=> rd_valid);

  // R2
  valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |=> !rd_valid);

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_idle && !$past(burst_idle)) |=> burst_idle);

  // R6
  ref_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ld_n && burst_idle) |=> (rd_ref_in_clk == $past(use_in_clk_ref)));

  // R6
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> $stable(rd_ref_in_clk));

  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_rise == '0 && rd_fall == '0));
endmodule

bind ddr_b4_sram ddr_b4_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ld_n      (cmd_ld_n),
  .cmd_rd_nwr    (cmd_rd_nwr),
  .use_in_clk_ref(use_in_clk_ref),
  .burst_idle    (burst_idle),
  .rd_valid      (rd_valid),
  .rd_rise       (rd_rise),
  .rd_fall       (rd_fall),
  .rd_ref_in_clk (rd_ref_in_clk)
);

// File: tb/test_ddr_b4_sram.sv
module test_ddr_b4_sram;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [DW-1:0] r;
    logic [DW-1:0] f;
    logic          rf;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_ld_n = 1'b1;
  logic          cmd_rd_nwr = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          use_in_clk_ref = 1'b0;
  logic [DW-1:0] wr_rise = '0;
  logic [DW-1:0] wr_fall = '0;
  logic [DW-1:0] rd_rise;
  logic [DW-1:0] rd_fall;
  logic          rd_valid;
  logic          rd_ref_in_clk;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  logic [DW-1:0] mdl [DEPTH];
  exp_t q[$];

  always #4 clk = ~clk;

  ddr_b4_sram #(.ADDR_W(AW), .DATA_W(DW)) i_ddr_b4_sram (.*);

  function automatic logic [DW-1:0] pat(input int s);
    logic [31:0] h;
    h = s * 32'h9E3779B1 + 32'h1234;
    return {h[7:4], h};
  endfunction

  function automatic logic [AW-1:0] slot(input logic [AW-1:0] a, input int k);
    logic [1:0] o;
    o = a[1:0] + 2'(k);
    return {a[AW-1:2], o};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4: words 0,1 in the cycle after load, words 2,3 in the next; R5 inject a read
  task automatic do_write(input logic [AW-1:0] a, input int seed, input bit inject);
    logic [DW-1:0] w [4];
    for (int k = 0; k < 4; k++) begin
      w[k] = pat(seed + k);
      mdl[slot(a, k)] = w[k];
    end
    @(negedge clk);
    cmd_ld_n = 0; cmd_rd_nwr = 0; cmd_addr = a;
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      cmd_ld_n = !inject; cmd_rd_nwr = 1; cmd_addr = ~a;
      wr_rise = w[2*c]; wr_fall = w[2*c+1];
    end
  endtask

  // R2/R3/R6 expected beats; R5 inject a write with junk data
  task automatic do_read(input logic [AW-1:0] a, input bit rf, input bit inject,
                         input logic [AW-1:0] junk_a);
    @(negedge clk);
    cmd_ld_n = 0; cmd_rd_nwr = 1; cmd_addr = a; use_in_clk_ref = rf;
    for (int c = 0; c < 2; c++) begin
      exp_t e;
      e.r = mdl[slot(a, 2*c)];
      e.f = mdl[slot(a, 2*c+1)];
      e.rf = rf;
      q.push_back(e);
    end
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      cmd_ld_n = !inject; cmd_rd_nwr = 0; cmd_addr = junk_a;
      use_in_clk_ref = !rf;
      wr_rise = pat(999 + c); wr_fall = pat(1999 + c);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_ld_n = 1;
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_valid) begin
        if (q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2 actual=rd_valid 1 expected=rd_valid 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R3 rise beat", rd_rise, e.r);
          chk("R3 fall beat", rd_fall, e.f);
          chk("R6 reference", DW'(rd_ref_in_clk), DW'(e.rf));
        end
      end else begin
        chk("R7 idle rise zero", rd_rise, '0);
        chk("R7 idle fall zero", rd_fall, '0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R7 reset valid", DW'(rd_valid), '0);
    mon_on = 1;
    // R8: fill every group back to back
    for (int g = 0; g < DEPTH / 4; g++) do_write(AW'(g * 4), g * 8, 1'b0);
    idle(1);
    do_read(6'd0, 1'b0, 1'b0, '0);          // R2 offset 0
    do_read(6'd6, 1'b1, 1'b0, '0);          // R3 offset 2 -> 2,3,0,1
    do_read(6'd11, 1'b0, 1'b0, '0);         // R3 offset 3 -> 3,0,1,2
    idle(2);
    do_write(6'd22, 500, 1'b0);             // R4 offset 2 write
    do_read(6'd20, 1'b1, 1'b0, '0);         // R8 read right after write
    do_write(6'd33, 600, 1'b1);             // R5 read pressed into write
    do_read(6'd33, 1'b0, 1'b1, 6'd45);      // R5 write pressed into read
    idle(1);
    do_read(6'd44, 1'b1, 1'b0, '0);         // R5 junk target unchanged
    do_read(6'd45, 1'b0, 1'b0, '0);
    idle(4);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R2 actual=%0d pending expected=0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule